// File: doc/BRIEF.md
# Base and Bound Address Translator

This block relocates and range-checks the addresses a simple multiprogrammed processor issues. It holds two independent relocation windows. One covers instruction fetch and the other covers loads and stores. Each window is a base and a limit register. A fetch address, or a data effective address (source register plus immediate), is compared unsigned against the limit of its window. The base of that window is then added to form the physical address.

For data accesses, the base, the source register and the immediate go through one three-input carry-save stage and then a single carry-propagate adder. This replaces two chained adders. An access above its limit is reported as a violation, and its valid is withheld so that nothing reaches memory.

The four window registers are loaded through a configuration port. The port accepts writes only when the supervisor-mode input is high. A write attempted in user mode changes nothing and is flagged. Translation is combinational, and all results are registered once together with the request valid.

Top module: `bb_xlate`

## Requirements
- R1: After reset, every output is low, and all four window registers are zero. With the limits at zero, only logical address zero is admitted on either path, and its physical address is zero.
- R2: A fetch request's physical address, shown one cycle after the request, is the fetch address plus the fetch base, modulo 2^AW.
- R3: A fetch address greater (unsigned) than the fetch limit gives a violation pulse and no valid one cycle later. An address equal to the limit is admitted.
- R4: A data request's physical address, shown one cycle after the request, is source plus immediate plus data base, modulo 2^AW.
- R5: The data logical address is source plus immediate modulo 2^AW, so a wrapping sum is checked after the wrap. If this logical address is above the data limit, a data violation pulse is given and no valid.
- R6: A supervisor write loads one register chosen by the select: 0 is the fetch base, 1 the fetch limit, 2 the data base and 3 the data limit. A request in the same cycle as the write still uses the old value, and the new value applies from the next cycle.
- R7: A write with supervisor mode low leaves all registers unchanged and raises the write-error output for exactly the following cycle.
- R8: A cycle with no request gives valid and violation low on that path in the next cycle, and the physical address output holds its last value.
- R9: The two windows are independent: writing data registers does not alter fetch translation, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 fetch base, 1 fetch limit, 2 data base, 3 data limit) |
| cfg_wdata | input | AW | Configuration write value |
| sup_mode | input | 1 | Supervisor mode; writes are accepted only when high |
| cfg_err | output | 1 | One-cycle pulse after a rejected user-mode write |
| if_req | input | 1 | Fetch request |
| if_addr | input | AW | Fetch logical address |
| if_vld | output | 1 | Fetch admitted, physical address valid |
| if_viol | output | 1 | Fetch limit violation |
| if_paddr | output | AW | Fetch physical address |
| dm_req | input | 1 | Data request |
| dm_rs | input | AW | Data source register value |
| dm_imm | input | AW | Data immediate, already extended |
| dm_vld | output | 1 | Data access admitted |
| dm_viol | output | 1 | Data limit violation |
| dm_paddr | output | AW | Data physical address |

## Verification
The bench builds the block with its default width of AW = 32. At this width, immediates of all ones act as negative offsets that wrap the effective address. It also places the data base at the top half of the space, so the carry-save result is checked across carries into the most significant bit. Limits are set to small values and probed at the limit, one above it and at the top of the range. This exercises the unsigned comparison at its equality boundary and at its extreme.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        SEL_FBASE  = 2'd0,
        SEL_FLIMIT = 2'd1,
        SEL_DBASE  = 2'd2,
        SEL_DLIMIT = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/bb_csa.sv
module bb_csa #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum
);

    logic [W-1:0] part_s;
    logic [W-1:0] part_c;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign part_s[i] = x[i] ^ y[i] ^ z[i];
        assign part_c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end

    assign sum = part_s + {part_c[W-2:0], 1'b0};

endmodule

// File: rtl/bb_path.sv
module bb_path #(
    parameter int AW      = 32,
    parameter bit USE_CSA = 1'b1
) (
    input  logic [AW-1:0] opa,
    input  logic [AW-1:0] opb,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] paddr,
    output logic          viol
);

    logic [AW-1:0] logical;

    assign logical = opa + opb;
    assign viol    = logical > limit;

    if (USE_CSA) begin : g_csa
        bb_csa #(.W(AW)) u_csa (
            .x   (opa),
            .y   (opb),
            .z   (base),
            .sum (paddr)
        );
    end else begin : g_chain
        assign paddr = logical + base;
    end

endmodule

// File: rtl/bb_regs.sv
module bb_regs
    import bb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sup,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] fbase,
    output logic [AW-1:0] flimit,
    output logic [AW-1:0] dbase,
    output logic [AW-1:0] dlimit,
    output logic          denied
);

    typedef struct packed {
        logic [AW-1:0] fbase;
        logic [AW-1:0] flimit;
        logic [AW-1:0] dbase;
        logic [AW-1:0] dlimit;
        logic          denied;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.denied = we & ~sup;
        if (we && sup) begin
            case (cfg_sel_e'(sel))
                SEL_FBASE:  st_d.fbase  = wdata;
                SEL_FLIMIT: st_d.flimit = wdata;
                SEL_DBASE:  st_d.dbase  = wdata;
                default:    st_d.dlimit = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fbase  = st_q.fbase;
    assign flimit = st_q.flimit;
    assign dbase  = st_q.dbase;
    assign dlimit = st_q.dlimit;
    assign denied = st_q.denied;

    AST_USER_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sup) |=> $stable({fbase, flimit, dbase, dlimit})); // R7

    AST_SUP_WRITE_FLIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sup && sel == 2'd1) |=> (flimit == $past(wdata))); // R6

    AST_SUP_WRITE_DBASE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sup && sel == 2'd2) |=> (dbase == $past(wdata) && $stable(fbase))); // R9

endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
    import bb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          sup_mode,
    output logic          cfg_err,
    input  logic          if_req,
    input  logic [AW-1:0] if_addr,
    output logic          if_vld,
    output logic          if_viol,
    output logic [AW-1:0] if_paddr,
    input  logic          dm_req,
    input  logic [AW-1:0] dm_rs,
    input  logic [AW-1:0] dm_imm,
    output logic          dm_vld,
    output logic          dm_viol,
    output logic [AW-1:0] dm_paddr
);

    typedef struct packed {
        logic          if_vld;
        logic          if_viol;
        logic [AW-1:0] if_paddr;
        logic          dm_vld;
        logic          dm_viol;
        logic [AW-1:0] dm_paddr;
    } out_t;

    logic [AW-1:0] fbase, flimit, dbase, dlimit;
    logic [AW-1:0] f_pa, d_pa;
    logic          f_bad, d_bad;
    out_t          out_d, out_q;

    bb_regs #(.AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sup    (sup_mode),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .fbase  (fbase),
        .flimit (flimit),
        .dbase  (dbase),
        .dlimit (dlimit),
        .denied (cfg_err)
    );

    bb_path #(.AW(AW), .USE_CSA(1'b0)) u_fetch (
        .opa   (if_addr),
        .opb   ('0),
        .base  (fbase),
        .limit (flimit),
        .paddr (f_pa),
        .viol  (f_bad)
    );

    bb_path #(.AW(AW), .USE_CSA(1'b1)) u_data (
        .opa   (dm_rs),
        .opb   (dm_imm),
        .base  (dbase),
        .limit (dlimit),
        .paddr (d_pa),
        .viol  (d_bad)
    );

    always_comb begin
        out_d         = out_q;
        out_d.if_vld  = if_req & ~f_bad;
        out_d.if_viol = if_req & f_bad;
        out_d.dm_vld  = dm_req & ~d_bad;
        out_d.dm_viol = dm_req & d_bad;
        if (if_req) out_d.if_paddr = f_pa;
        if (dm_req) out_d.dm_paddr = d_pa;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign if_vld   = out_q.if_vld;
    assign if_viol  = out_q.if_viol;
    assign if_paddr = out_q.if_paddr;
    assign dm_vld   = out_q.dm_vld;
    assign dm_viol  = out_q.dm_viol;
    assign dm_paddr = out_q.dm_paddr;

    AST_FETCH_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        if_req |=> (if_paddr == $past(if_addr + fbase))); // R2

    AST_FETCH_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && if_addr > flimit) |=> (if_viol && !if_vld)); // R3

    AST_DATA_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req |=> (dm_paddr == $past(dm_rs + dm_imm + dbase))); // R4

    AST_DATA_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && AW'(dm_rs + dm_imm) > dlimit) |=> (dm_viol && !dm_vld)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_req && !dm_req) |=> (!if_vld && !if_viol && !dm_vld && !dm_viol
                                  && $stable(if_paddr) && $stable(dm_paddr))); // R8

    AST_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !sup_mode) |=> cfg_err); // R7

endmodule

// File: tb/bb_xlate_test.sv
module bb_xlate_test;

    localparam int AW = 32;
    localparam logic [31:0] FB = 32'h0001_0000;
    localparam logic [31:0] FL = 32'h0000_0FFF;
    localparam logic [31:0] DB = 32'h8000_0000;
    localparam logic [31:0] DL = 32'h0000_3FFF;

    // fetch addr, rs, imm, expect fetch viol, expect data viol
    typedef struct packed {
        logic [31:0] fa;
        logic [31:0] rs;
        logic [31:0] imm;
        logic        fv;
        logic        dv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h0000_0FFF, 32'h0000_1000, 32'hFFFF_FFFF, 1'b0, 1'b0},
        '{32'h0000_1000, 32'h0000_3FFF, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h0000_0800, 32'h0000_3FFF, 32'h0000_0001, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFE, 1'b1, 1'b0},
        '{32'h0000_0010, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1},
        '{32'h0000_0123, 32'h0000_0100, 32'h0000_0200, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          sup_mode = 1'b0;
    logic          cfg_err;
    logic          if_req = 1'b0;
    logic [AW-1:0] if_addr = '0;
    logic          if_vld, if_viol;
    logic [AW-1:0] if_paddr;
    logic          dm_req = 1'b0;
    logic [AW-1:0] dm_rs = '0, dm_imm = '0;
    logic          dm_vld, dm_viol;
    logic [AW-1:0] dm_paddr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bb_xlate #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sup_mode(sup_mode), .cfg_err(cfg_err),
        .if_req(if_req), .if_addr(if_addr), .if_vld(if_vld), .if_viol(if_viol),
        .if_paddr(if_paddr), .dm_req(dm_req), .dm_rs(dm_rs), .dm_imm(dm_imm),
        .dm_vld(dm_vld), .dm_viol(dm_viol), .dm_paddr(dm_paddr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] val, input logic sup);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val; sup_mode = sup;
        @(negedge clk);
        cfg_we = 1'b0; sup_mode = 1'b0;
    endtask

    // issue one request on both paths; outputs are checked one cycle later
    task automatic issue(input logic [31:0] fa, input logic [31:0] rs, input logic [31:0] imm);
        @(negedge clk);
        if_req = 1'b1; if_addr = fa;
        dm_req = 1'b1; dm_rs = rs; dm_imm = imm;
        @(negedge clk);
        if_req = 1'b0; dm_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 outputs", {if_vld, if_viol, dm_vld, dm_viol, cfg_err}, 64'd0);
        chk("R1 paddr", {if_paddr, dm_paddr}, 64'd0);
        issue(32'd0, 32'd0, 32'd0);
        chk("R1 addr zero admitted", {if_vld, if_viol, dm_vld, dm_viol}, 64'b1010);
        chk("R1 zero base", {if_paddr, dm_paddr}, 64'd0);
        issue(32'd1, 32'd0, 32'd1);
        chk("R1 addr one faults", {if_vld, if_viol, dm_vld, dm_viol}, 64'b0101);

        // R7: user-mode write rejected and flagged
        cfg(2'd1, 32'hFFFF_FFFF, 1'b0);
        chk("R7 cfg_err pulse", {63'd0, cfg_err}, 64'd1);
        @(negedge clk);
        chk("R7 cfg_err one cycle", {63'd0, cfg_err}, 64'd0);
        issue(32'd1, 32'd0, 32'd0);
        chk("R7 limit unchanged", {62'd0, if_vld, if_viol}, 64'b01);

        // R6: supervisor writes
        cfg(2'd0, FB, 1'b1);
        chk("R6 no err on sup write", {63'd0, cfg_err}, 64'd0);
        cfg(2'd1, FL, 1'b1);
        cfg(2'd2, DB, 1'b1);
        cfg(2'd3, DL, 1'b1);

        // R2 R3 R4 R5: vector walk
        for (int i = 0; i < NV; i++) begin
            issue(VT[i].fa, VT[i].rs, VT[i].imm);
            chk("R3 fetch flags", {62'd0, if_vld, if_viol}, {62'd0, ~VT[i].fv, VT[i].fv});
            chk("R2 fetch paddr", {32'd0, if_paddr}, {32'd0, VT[i].fa + FB});
            chk("R5 data flags", {62'd0, dm_vld, dm_viol}, {62'd0, ~VT[i].dv, VT[i].dv});
            chk("R4 data paddr", {32'd0, dm_paddr}, {32'd0, VT[i].rs + VT[i].imm + DB});
        end

        // R8: idle cycle quiet, addresses hold
        @(negedge clk);
        chk("R8 idle flags", {if_vld, if_viol, dm_vld, dm_viol}, 64'd0);
        chk("R8 paddr hold", {if_paddr, dm_paddr}, {32'h0001_0123, 32'h8000_0300});

        // R6: request in the same cycle as a write uses the old limit
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0000_4000; sup_mode = 1'b1;
        dm_req = 1'b1; dm_rs = 32'h0000_4000; dm_imm = '0;
        @(negedge clk);
        cfg_we = 1'b0; sup_mode = 1'b0;
        chk("R6 old limit used", {62'd0, dm_vld, dm_viol}, 64'b01);
        @(negedge clk);
        dm_req = 1'b0;
        chk("R6 new limit applies", {62'd0, dm_vld, dm_viol}, 64'b10);

        // R9: data writes leave fetch translation alone
        cfg(2'd3, 32'd0, 1'b1);
        cfg(2'd2, 32'h1234_0000, 1'b1);
        @(negedge clk);
        if_req = 1'b1; if_addr = 32'h0000_0FFF;
        @(negedge clk);
        if_req = 1'b0;
        chk("R9 fetch unaffected", {31'd0, if_vld, if_paddr}, {31'd0, 1'b1, 32'h0001_0FFF});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule